// File: doc/BRIEF.md
# Shared-RAM Host Access Sequencer

This block runs the host side of a shared RAM and register file that an internal protocol engine also uses. The host asks for a transfer by pulling its strobe and its select low together. The sequencer holds the request until the engine no longer owns the RAM. It then drops an active-low transfer-start output and captures the access type and the address. After a fixed number of wait states it pulls an active-low ready low, and it ends the cycle once the host lets the strobe go.

The access type is sampled on the falling clock edge inside the first cycle of the transfer. The address is sampled on the rising edge that follows the start. The address comes from an internal bus that either follows the address pins or holds them, as set by an address-track input. This lets a multiplexed host bus be split apart inside the block. The engine's arbitration grant is issued and withdrawn here, so the engine can never own the RAM while a host transfer is running.

Top module: `hostram_seq`

## Requirements
- R1: While reset is asserted, and right after it, xfer_n and rdy_n are high, eng_grant is low, all four access strobes are low, and lat_mem, lat_rd and lat_addr are zero.
- R2: With the sequencer idle and eng_grant low, a rising edge that sees strobe_n and select_n both low starts a transfer. xfer_n is low from that edge on.
- R3: No transfer starts while select_n is high or while eng_grant is high. The request waits and starts on the first rising edge at which both conditions are clear.
- R4: lat_mem (1 = RAM, 0 = register) and lat_rd (1 = read, 0 = write) take mem_sel and rd_wr at the first falling edge after the start. Later changes to those inputs have no effect until the next transfer.
- R5: lat_addr takes the internal address bus at the first rising edge after xfer_n falls. It then holds until the next transfer, whatever the address pins do.
- R6: While addr_track is high, the internal address bus equals addr_in. While it is low, the bus holds the addr_in value last sampled at a rising edge while addr_track was high.
- R7: rdy_n goes low on the 3rd rising edge after the start edge. For a register read (lat_mem=0, lat_rd=1) it goes low on the 7th rising edge instead.
- R8: Once rdy_n is low, the first rising edge that sees strobe_n high returns xfer_n and rdy_n high. At that same edge eng_grant takes the value of eng_req.
- R9: When idle and no host transfer starts, eng_grant follows eng_req one edge later. From the start edge until the end edge of a host transfer, eng_grant stays low, so an engine request is deferred.
- R10: On the 2nd rising edge after the start, exactly one strobe goes high for one cycle: ram_rd_stb, ram_wr_stb, reg_rd_stb or reg_wr_stb, chosen by lat_mem and lat_rd. At all other times the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Host transfer strobe, active low |
| select_n | input | 1 | Host chip select, active low |
| mem_sel | input | 1 | 1 = RAM access, 0 = register access |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr_in | input | 16 | Host address pins |
| addr_track | input | 1 | 1 = internal address bus follows pins, 0 = hold |
| eng_req | input | 1 | Protocol engine wants the RAM |
| xfer_n | output | 1 | Transfer in progress, active low |
| rdy_n | output | 1 | Data ready / write stored, active low |
| lat_mem | output | 1 | Captured RAM/register select |
| lat_rd | output | 1 | Captured read/write select |
| lat_addr | output | 16 | Captured address |
| ram_rd_stb | output | 1 | One-cycle RAM read strobe |
| ram_wr_stb | output | 1 | One-cycle RAM write strobe |
| reg_rd_stb | output | 1 | One-cycle register read strobe |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| eng_grant | output | 1 | RAM granted to the protocol engine |

## Verification
The assertions assume the host obeys the handshake: strobe_n stays low from the request until rdy_n has fallen, and it goes high before the next request. Without that, the end-of-cycle and grant properties lose their meaning. The stimulus drives every input a little after a falling edge, so access type and address are stable at the edges that capture them. It releases the strobe only after it has seen ready low. Changes to the control and address pins in the middle of a transfer are made only after the capture edges, so that they exercise the hold behaviour and not a setup race.

// File: rtl/hostram_pkg.sv
package hostram_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ram_rd;
        logic ram_wr;
        logic reg_rd;
        logic reg_wr;
    } acc_stb_t;

    function automatic acc_stb_t decode_access(input logic is_mem, input logic is_rd);
        acc_stb_t s;
        s.ram_rd = is_mem & is_rd;
        s.ram_wr = is_mem & ~is_rd;
        s.reg_rd = ~is_mem & is_rd;
        s.reg_wr = ~is_mem & ~is_rd;
        return s;
    endfunction

endpackage

// File: rtl/hostram_addr_latch.sv
module hostram_addr_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         track,
    input  logic [W-1:0] pins,
    output logic [W-1:0] bus
);
    logic [W-1:0] hold_d, hold_q;

    // the hold register refreshes only while tracking
    always_comb begin
        hold_d = track ? pins : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign bus = track ? pins : hold_q;
endmodule

// File: rtl/hostram_ctrl_capture.sv
module hostram_ctrl_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic mem_in,
    input  logic rd_in,
    output logic mem_q,
    output logic rd_q
);
    logic mem_d, rd_d;

    always_comb begin
        mem_d = cap_en ? mem_in : mem_q;
        rd_d  = cap_en ? rd_in  : rd_q;
    end

    // falling-edge capture of the access type
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end
endmodule

// File: rtl/hostram_seq.sv
module hostram_seq
    import hostram_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BASE_LAT   = 3,
    parameter int REG_RD_LAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              select_n,
    input  logic              mem_sel,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_track,
    input  logic              eng_req,
    output logic              xfer_n,
    output logic              rdy_n,
    output logic              lat_mem,
    output logic              lat_rd,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              ram_rd_stb,
    output logic              ram_wr_stb,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb,
    output logic              eng_grant
);
    localparam int CNT_W = $clog2(REG_RD_LAT + 1);
    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE_LAT - 1);
    localparam logic [CNT_W-1:0] RRD_M1  = CNT_W'(REG_RD_LAT - 1);
    localparam logic [CNT_W-1:0] STB_AT  = CNT_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              xfer_n;
        logic              rdy_n;
        logic              grant;
        logic [ADDR_W-1:0] addr;
        acc_stb_t          stb;
    } seq_regs_t;

    seq_regs_t q, d;
    logic [ADDR_W-1:0] int_bus;
    logic              cap_en;
    logic              host_req;
    logic [CNT_W-1:0]  last_cnt;

    hostram_addr_latch #(.W(ADDR_W)) u_alat (
        .clk   (clk),
        .rst_n (rst_n),
        .track (addr_track),
        .pins  (addr_in),
        .bus   (int_bus)
    );

    // open only during the half cycle after the start edge
    assign cap_en = (q.st == SEQ_WAIT) && (q.cnt == '0);

    hostram_ctrl_capture u_ccap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .mem_in (mem_sel),
        .rd_in  (rd_wr),
        .mem_q  (lat_mem),
        .rd_q   (lat_rd)
    );

    assign host_req = !strobe_n && !select_n;
    assign last_cnt = (!lat_mem && lat_rd) ? RRD_M1 : BASE_M1;

    always_comb begin
        d     = q;
        d.stb = '0;
        unique case (q.st)
            SEQ_IDLE: begin
                if (host_req && !q.grant) begin
                    d.st     = SEQ_WAIT;
                    d.cnt    = '0;
                    d.xfer_n = 1'b0;
                    d.grant  = 1'b0;
                end else begin
                    d.grant  = eng_req;
                end
            end
            SEQ_WAIT: begin
                d.grant = 1'b0;
                if (q.cnt == '0)    d.addr = int_bus;
                if (q.cnt == STB_AT) d.stb = decode_access(lat_mem, lat_rd);
                if (q.cnt == last_cnt) begin
                    d.rdy_n = 1'b0;
                    d.st    = SEQ_DONE;
                end
                d.cnt = q.cnt + 1'b1;
            end
            SEQ_DONE: begin
                if (strobe_n) begin
                    d.st     = SEQ_IDLE;
                    d.xfer_n = 1'b1;
                    d.rdy_n  = 1'b1;
                    d.grant  = eng_req;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= SEQ_IDLE;
            q.xfer_n <= 1'b1;
            q.rdy_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign xfer_n     = q.xfer_n;
    assign rdy_n      = q.rdy_n;
    assign lat_addr   = q.addr;
    assign ram_rd_stb = q.stb.ram_rd;
    assign ram_wr_stb = q.stb.ram_wr;
    assign reg_rd_stb = q.stb.reg_rd;
    assign reg_wr_stb = q.stb.reg_wr;
    assign eng_grant  = q.grant;

    // R9: engine and host never own the RAM together
    assert_grant_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_grant && !xfer_n));

    // R7: ready only inside a transfer
    assert_rdy_in_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> !xfer_n);

    // R2/R3: a start needs a request seen with no engine grant
    assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_n) |-> ($past(host_req) && !$past(eng_grant)));

    // R8: end only after ready and a released strobe
    assert_end_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_n) |-> (!$past(rdy_n) && $past(strobe_n)));

    // R10: at most one access strobe
    assert_stb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd_stb, ram_wr_stb, reg_rd_stb, reg_wr_stb}));

    // R5: captured address holds after its capture edge
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SEQ_IDLE && q.cnt != '0) |=> $stable(lat_addr));
endmodule

// File: tb/hostram_seq_test.sv
module hostram_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_n = 1'b1, select_n = 1'b1, mem_sel = 1'b0, rd_wr = 1'b0;
    logic [15:0] addr_in = 16'h0;
    logic addr_track = 1'b1, eng_req = 1'b0;
    logic xfer_n, rdy_n, lat_mem, lat_rd, eng_grant;
    logic ram_rd_stb, ram_wr_stb, reg_rd_stb, reg_wr_stb;
    logic [15:0] lat_addr;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hostram_seq uut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .select_n(select_n),
        .mem_sel(mem_sel), .rd_wr(rd_wr), .addr_in(addr_in), .addr_track(addr_track),
        .eng_req(eng_req), .xfer_n(xfer_n), .rdy_n(rdy_n), .lat_mem(lat_mem),
        .lat_rd(lat_rd), .lat_addr(lat_addr), .ram_rd_stb(ram_rd_stb),
        .ram_wr_stb(ram_wr_stb), .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb),
        .eng_grant(eng_grant)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st = 0, m_cnt = 0;
    bit m_grant = 0, m_xfer_n = 1, m_rdy_n = 1, m_mem = 0, m_rd = 0;
    logic [15:0] m_hold = 0, m_addr = 0;
    logic [3:0] m_stb = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_grant = 0; m_xfer_n = 1; m_rdy_n = 1;
            m_hold = 0; m_addr = 0; m_stb = 0;
        end else begin
            logic [15:0] bus;
            int lat;
            bus = addr_track ? addr_in : m_hold;
            m_stb = 0;
            if (m_st == 0) begin
                if (!strobe_n && !select_n && !m_grant) begin
                    m_st = 1; m_cnt = 0; m_xfer_n = 0; m_grant = 0;
                end else m_grant = eng_req;
            end else if (m_st == 1) begin
                m_grant = 0;
                if (m_cnt == 0) m_addr = bus;
                if (m_cnt == 1) m_stb = {m_mem & m_rd, m_mem & !m_rd, !m_mem & m_rd, !m_mem & !m_rd};
                lat = (!m_mem && m_rd) ? 7 : 3;
                if (m_cnt + 1 == lat) begin m_rdy_n = 0; m_st = 2; end
                m_cnt++;
            end else if (strobe_n) begin
                m_st = 0; m_xfer_n = 1; m_rdy_n = 1; m_grant = eng_req;
            end
            if (addr_track) m_hold = addr_in;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin m_mem = 0; m_rd = 0; end
        else if (m_st == 1 && m_cnt == 0) begin m_mem = mem_sel; m_rd = rd_wr; end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk(xfer_n === m_xfer_n, "R2 xfer_n", xfer_n, m_xfer_n);
            chk(rdy_n === m_rdy_n, "R7 rdy_n", rdy_n, m_rdy_n);
            chk(eng_grant === m_grant, "R9 eng_grant", eng_grant, m_grant);
            chk(lat_addr === m_addr, "R5 lat_addr", lat_addr, m_addr);
            chk({lat_mem, lat_rd} === {m_mem, m_rd}, "R4 lat ctrl", {lat_mem, lat_rd}, {m_mem, m_rd});
            chk({ram_rd_stb, ram_wr_stb, reg_rd_stb, reg_wr_stb} === m_stb, "R10 strobes",
                {ram_rd_stb, ram_wr_stb, reg_rd_stb, reg_wr_stb}, m_stb);
        end
    end

    // waits for ready, measures latency, optionally disturbs inputs, then ends the cycle
    task automatic finish_xfer(input logic [15:0] ea, input logic er, input int exp_lat,
                               input bit flip, input bit eng_mid);
        int t0 = -1, t1 = -1;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #2;
            if (t0 < 0 && !xfer_n) t0 = cyc;
            if (!rdy_n) begin t1 = cyc; break; end
            if (t0 >= 0 && cyc == t0 + 1) begin
                #5;
                if (flip) begin rd_wr = ~rd_wr; mem_sel = ~mem_sel; addr_in = ~addr_in; end
                if (eng_mid) eng_req = 1'b1;
            end
        end
        chk(t0 >= 0 && t1 - t0 == exp_lat, "R7 latency", t1 - t0, exp_lat);
        chk(lat_addr === ea, "R5 captured address", lat_addr, ea);
        chk(lat_rd === er, "R4 captured read/write", lat_rd, er);
        if (eng_mid) chk(eng_grant === 1'b0, "R9 deferred grant", eng_grant, 0);
        #3; strobe_n = 1'b1; select_n = 1'b1;
        @(posedge clk); #2;
        chk(xfer_n === 1'b1 && rdy_n === 1'b1, "R8 end of cycle", {xfer_n, rdy_n}, 2'b11);
        chk(eng_grant === eng_req, "R8 grant handover", eng_grant, eng_req);
    endtask

    task automatic do_xfer(input logic m, input logic r, input logic [15:0] a,
                           input logic [15:0] ea, input int exp_lat, input bit flip, input bit eng_mid);
        @(posedge clk); #7;
        mem_sel = m; rd_wr = r; addr_in = a; strobe_n = 1'b0; select_n = 1'b0;
        finish_xfer(ea, r, exp_lat, flip, eng_mid);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #23;
        chk(xfer_n === 1 && rdy_n === 1 && eng_grant === 0, "R1 reset outputs",
            {xfer_n, rdy_n, eng_grant}, 3'b110);
        chk({ram_rd_stb, ram_wr_stb, reg_rd_stb, reg_wr_stb, lat_mem, lat_rd} === 6'b0 && lat_addr === 16'h0,
            "R1 reset latches", lat_addr, 0);
        @(posedge clk); #7; rst_n = 1'b1;
        @(posedge clk); #2;
        chk(xfer_n === 1 && rdy_n === 1 && eng_grant === 0, "R1 after reset", {xfer_n, rdy_n, eng_grant}, 3'b110);

        do_xfer(1, 0, 16'h1234, 16'h1234, 3, 0, 0);   // RAM write
        do_xfer(1, 1, 16'hABCD, 16'hABCD, 3, 0, 0);   // RAM read
        do_xfer(0, 0, 16'h0042, 16'h0042, 3, 0, 0);   // register write
        do_xfer(0, 1, 16'h0007, 16'h0007, 7, 0, 0);   // register read (R7 long)
        do_xfer(0, 1, 16'h5A5A, 16'h5A5A, 7, 1, 0);   // R4/R5: later pin changes ignored

        // R3: select high blocks a start
        @(posedge clk); #7; strobe_n = 1'b0; select_n = 1'b1;
        repeat (3) @(posedge clk); #2;
        chk(xfer_n === 1'b1, "R3 select high blocks", xfer_n, 1);
        #5; strobe_n = 1'b1;

        // R9/R3: engine owns the RAM, host waits
        eng_req = 1'b1;
        repeat (2) @(posedge clk); #2;
        chk(eng_grant === 1'b1, "R9 engine granted", eng_grant, 1);
        #5; mem_sel = 1; rd_wr = 1; addr_in = 16'h7777; strobe_n = 1'b0; select_n = 1'b0;
        repeat (4) @(posedge clk); #2;
        chk(xfer_n === 1'b1, "R3 waits for engine", xfer_n, 1);
        #5; eng_req = 1'b0;
        finish_xfer(16'h7777, 1, 3, 0, 0);

        // R9/R8: engine request mid-transfer is deferred then granted
        do_xfer(1, 0, 16'h0F0F, 16'h0F0F, 3, 0, 1);
        chk(eng_grant === 1'b1, "R8 grant after transfer", eng_grant, 1);
        @(posedge clk); #7; eng_req = 1'b0;
        repeat (2) @(posedge clk);

        // R6: address held while tracking is off
        @(posedge clk); #7; addr_in = 16'hC0DE; addr_track = 1'b1;
        @(posedge clk); #7; addr_track = 1'b0;
        do_xfer(1, 1, 16'hBEEF, 16'hC0DE, 3, 0, 0);
        chk(lat_addr === 16'hC0DE, "R6 held address used", lat_addr, 16'hC0DE);
        @(posedge clk); #7; addr_track = 1'b1;
        do_xfer(1, 1, 16'h2468, 16'h2468, 3, 0, 0);   // R6 tracking again

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule